// File: doc/BRIEF.md
# Stream-to-Memory Ring Burst Writer

This block accepts a continuous stream of 64-bit sample words on an AXI4-Stream slave port and stores them in a circular buffer in byte-addressed external memory. It writes through an AXI memory-mapped write master. Incoming words wait in a small FIFO. Once sixteen words are waiting, the block issues one fixed-length burst: first the address phase, then sixteen data beats, then it waits for the write response. Only one burst is in flight at any time.

Software programs the byte base address of the buffer and watches a word counter. The counter counts 64-bit words whose burst has been acknowledged, and it wraps at a power of two set by a parameter. The byte address of the next write is therefore base + 8 × counter. Clearing the enable input parks the block and returns the counter to zero. A burst that has already started still finishes. The block also counts write responses and keeps a sticky error flag for any response other than OKAY.

Top module: `ring_burst_writer`

## Requirements
- R1: After reset the word counter, the response count and the error flag are zero, and no address, data or response handshake signal is asserted. `s_axis_tready` is high when enable is high.
- R2: Every burst has AWLEN = 15, AWSIZE = 3 (8 bytes per beat) and AWBURST = 2'b01 (INCR). Every beat has WSTRB = 8'hFF. WLAST is high on the 16th beat and on no other beat.
- R3: The burst address equals the base address with its bits [6:0] cleared, plus 8 × the word counter at the moment the burst is issued. Base bits [6:0] are ignored, so every burst begins on a 128-byte boundary.
- R4: An address phase starts only when at least 16 words are held in the FIFO.
- R5: Data beats carry the accepted stream words in acceptance order, with no loss and no duplication.
- R6: Each write response handshake adds 16 to the word counter. The counter wraps to zero at 2^CNT_W.
- R7: `s_axis_tready` is high exactly when enable is high and the FIFO holds fewer than FIFO_DEPTH words.
- R8: While enable is low, the word counter reads zero and no new burst is issued. A burst already issued still completes its data and response phases.
- R9: The phases run strictly in order: address, then 16 data beats, then the response. The next address phase comes only after the previous response handshake.
- R10: Each response handshake increments the response count by one.
- R11: A response with BRESP other than 2'b00 sets the error flag. The flag stays set until reset.
- R12: AWVALID and AWADDR hold steady until AWREADY. WVALID and WDATA hold steady until WREADY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable; low parks the block and zeroes the counter |
| base_addr_i | input | ADDR_W | Byte base address of the ring buffer |
| word_cnt_o | output | CNT_W | Words acknowledged by memory, modulo 2^CNT_W |
| resp_cnt_o | output | RESP_W | Number of write responses received |
| err_o | output | 1 | Sticky flag for a non-OKAY write response |
| s_axis_tdata | input | 64 | Stream sample word |
| s_axis_tvalid | input | 1 | Stream word valid |
| s_axis_tready | output | 1 | Stream word accepted |
| m_axi_awaddr | output | ADDR_W | Burst byte address |
| m_axi_awlen | output | 8 | Burst length minus one (15) |
| m_axi_awsize | output | 3 | Beat size code (3 = 8 bytes) |
| m_axi_awburst | output | 2 | Burst type (INCR) |
| m_axi_awvalid | output | 1 | Address valid |
| m_axi_awready | input | 1 | Address accepted |
| m_axi_wdata | output | 64 | Write beat data |
| m_axi_wstrb | output | 8 | Byte strobes, all set |
| m_axi_wlast | output | 1 | Last beat of the burst |
| m_axi_wvalid | output | 1 | Write data valid |
| m_axi_wready | input | 1 | Write data accepted |
| m_axi_bresp | input | 2 | Write response code |
| m_axi_bvalid | input | 1 | Write response valid |
| m_axi_bready | output | 1 | Write response accepted |

## Verification
The hardest situation to reach is enable dropping while a burst is partway through its data beats. The counter must clear at once, but the remaining beats and the response must still arrive, and no further address may follow. The stimulus waits for WVALID under a stalling write-ready pattern, clears enable in the following cycle, and lets the cycle-by-cycle model in the bench check every beat, the counter and the absence of new bursts. A filled FIFO is reached by holding the address-ready input low while the stream runs at full rate. Counter wrap is reached by using a narrow counter parameter in the bench.

// File: rtl/rbw_pkg.sv
`timescale 1ns/1ps
package rbw_pkg;
    localparam int DATA_W      = 64;
    localparam int STRB_W      = DATA_W / 8;
    localparam int BEATS       = 16;
    localparam int BEAT_BYTES  = DATA_W / 8;
    localparam int BURST_BYTES = BEATS * BEAT_BYTES;
    localparam int BEAT_W      = $clog2(BEATS);

    localparam logic [7:0] AXI_LEN   = 8'(BEATS - 1);
    localparam logic [2:0] AXI_SIZE  = 3'($clog2(BEAT_BYTES));
    localparam logic [1:0] AXI_INCR  = 2'b01;
    localparam logic [1:0] AXI_OKAY  = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_RESP
    } wr_state_e;
endpackage

// File: rtl/rbw_fifo.sv
`timescale 1ns/1ps
module rbw_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.wr = st_q.wr + PTR_W'(1);
        end
        if (pop_i) begin
            st_d.rd = st_q.rd + PTR_W'(1);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.lvl = st_q.lvl + LVL_W'(1);
            2'b01:   st_d.lvl = st_q.lvl - LVL_W'(1);
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[st_q.wr] <= din_i;
        end
    end

    assign dout_o  = mem_q[st_q.rd];
    assign level_o = st_q.lvl;
    assign full_o  = (st_q.lvl == LVL_W'(DEPTH));

    // R7: the level never goes past the storage size
    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LVL_W'(DEPTH));

    // R5: a beat is never taken from an empty FIFO
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> st_q.lvl != '0);
endmodule

// File: rtl/rbw_burst_ctrl.sv
`timescale 1ns/1ps
module rbw_burst_ctrl
    import rbw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic              aw_ready_i,
    input  logic              w_ready_i,
    input  logic              b_valid_i,
    output logic              aw_valid_o,
    output logic [ADDR_W-1:0] aw_addr_o,
    output logic              w_valid_o,
    output logic              w_last_o,
    output logic              b_ready_o,
    output logic              pop_o,
    output logic              b_done_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BURST_BYTES - 1);
    localparam logic [CNT_W-1:0]  CNT_STEP   = CNT_W'(BEATS);

    typedef struct packed {
        wr_state_e         state;
        logic [BEAT_W-1:0] beat;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     last_beat;
    logic     burst_ok;

    assign last_beat = (st_q.beat == BEAT_W'(BEATS - 1));
    assign burst_ok  = en_i && (level_i >= LVL_W'(BEATS));

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            ST_IDLE: begin
                if (burst_ok) begin
                    st_d.state = ST_ADDR;
                    st_d.addr  = (base_i & ALIGN_MASK)
                               + ADDR_W'({st_q.cnt, 3'b000});
                end
            end
            ST_ADDR: begin
                if (aw_ready_i) begin
                    st_d.state = ST_DATA;
                    st_d.beat  = '0;
                end
            end
            ST_DATA: begin
                if (w_ready_i) begin
                    st_d.beat = st_q.beat + BEAT_W'(1);
                    if (last_beat) begin
                        st_d.state = ST_RESP;
                    end
                end
            end
            default: begin
                if (b_valid_i) begin
                    st_d.state = ST_IDLE;
                end
            end
        endcase
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (st_q.state == ST_RESP && b_valid_i) begin
            st_d.cnt = st_q.cnt + CNT_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, beat: '0, addr: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign aw_valid_o = (st_q.state == ST_ADDR);
    assign aw_addr_o  = st_q.addr;
    assign w_valid_o  = (st_q.state == ST_DATA);
    assign w_last_o   = w_valid_o && last_beat;
    assign b_ready_o  = (st_q.state == ST_RESP);
    assign pop_o      = w_valid_o && w_ready_i;
    assign b_done_o   = b_ready_o && b_valid_i;
    assign cnt_o      = st_q.cnt;

    // R12: address held until accepted
    a_r12_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid_o && !aw_ready_i |=> aw_valid_o && $stable(aw_addr_o));

    // R12: data valid held until accepted
    a_r12_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid_o && !w_ready_i |=> w_valid_o);

    // R8: a low enable leaves the counter at zero
    a_r8_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> cnt_o == '0);

    // R6: a response while enabled steps the counter by one burst
    a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && b_ready_o && b_valid_i |=> cnt_o == $past(cnt_o) + CNT_STEP);

    // R9: after the last beat is taken, the response phase follows
    a_r9_resp_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        w_last_o && w_ready_i |=> b_ready_o && !w_valid_o && !aw_valid_o);
endmodule

// File: rtl/rbw_resp_track.sv
`timescale 1ns/1ps
module rbw_resp_track
    import rbw_pkg::*;
#(
    parameter int RESP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [1:0]        resp_i,
    output logic [RESP_W-1:0] count_o,
    output logic              err_o
);
    typedef struct packed {
        logic [RESP_W-1:0] count;
        logic              err;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            st_d.count = st_q.count + RESP_W'(1);
            if (resp_i != AXI_OKAY) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign err_o   = st_q.err;

    // R11: the error flag never clears outside reset
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R11: a bad response raises the flag
    a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && resp_i != AXI_OKAY |=> err_o);

    // R10: every response is counted
    a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> count_o == $past(count_o) + RESP_W'(1));
endmodule

// File: rtl/ring_burst_writer.sv
`timescale 1ns/1ps
module ring_burst_writer
    import rbw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 10,
    parameter int FIFO_DEPTH = 32,
    parameter int RESP_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic [CNT_W-1:0]  word_cnt_o,
    output logic [RESP_W-1:0] resp_cnt_o,
    output logic              err_o,
    input  logic [DATA_W-1:0] s_axis_tdata,
    input  logic              s_axis_tvalid,
    output logic              s_axis_tready,
    output logic [ADDR_W-1:0] m_axi_awaddr,
    output logic [7:0]        m_axi_awlen,
    output logic [2:0]        m_axi_awsize,
    output logic [1:0]        m_axi_awburst,
    output logic              m_axi_awvalid,
    input  logic              m_axi_awready,
    output logic [DATA_W-1:0] m_axi_wdata,
    output logic [STRB_W-1:0] m_axi_wstrb,
    output logic              m_axi_wlast,
    output logic              m_axi_wvalid,
    input  logic              m_axi_wready,
    input  logic [1:0]        m_axi_bresp,
    input  logic              m_axi_bvalid,
    output logic              m_axi_bready
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic             push;
    logic             pop;
    logic             fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             b_done;

    assign s_axis_tready = en_i && !fifo_full;
    assign push          = s_axis_tvalid && s_axis_tready;

    rbw_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (s_axis_tdata),
        .pop_i   (pop),
        .dout_o  (m_axi_wdata),
        .level_o (fifo_level),
        .full_o  (fifo_full)
    );

    rbw_burst_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LVL_W  (LVL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .base_i     (base_addr_i),
        .level_i    (fifo_level),
        .aw_ready_i (m_axi_awready),
        .w_ready_i  (m_axi_wready),
        .b_valid_i  (m_axi_bvalid),
        .aw_valid_o (m_axi_awvalid),
        .aw_addr_o  (m_axi_awaddr),
        .w_valid_o  (m_axi_wvalid),
        .w_last_o   (m_axi_wlast),
        .b_ready_o  (m_axi_bready),
        .pop_o      (pop),
        .b_done_o   (b_done),
        .cnt_o      (word_cnt_o)
    );

    rbw_resp_track #(
        .RESP_W (RESP_W)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (b_done),
        .resp_i  (m_axi_bresp),
        .count_o (resp_cnt_o),
        .err_o   (err_o)
    );

    assign m_axi_awlen   = AXI_LEN;
    assign m_axi_awsize  = AXI_SIZE;
    assign m_axi_awburst = AXI_INCR;
    assign m_axi_wstrb   = '1;

    // R4: an address phase only with a full burst buffered
    a_r4_enough_words: assert property (@(posedge clk) disable iff (!rst_n)
        m_axi_awvalid |-> fifo_level >= LVL_W'(BEATS));

    // R7: a full FIFO stalls the stream
    a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !s_axis_tready);

    // R12: beat data held while the slave stalls
    a_r12_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        m_axi_wvalid && !m_axi_wready |=> $stable(m_axi_wdata));
endmodule

// File: tb/sim_ring_burst_writer.sv
`timescale 1ns/1ps
module sim_ring_burst_writer;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 8;
    localparam int DEPTH  = 32;
    localparam int RESP_W = 16;
    localparam int WDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b1;
    logic [ADDR_W-1:0] base = 32'h0000_1000;
    logic [CNT_W-1:0]  word_cnt;
    logic [RESP_W-1:0] resp_cnt;
    logic              err;
    logic [63:0]       tdata = '0;
    logic              tvalid = 1'b0;
    logic              tready;
    logic [ADDR_W-1:0] awaddr;
    logic [7:0]        awlen;
    logic [2:0]        awsize;
    logic [1:0]        awburst;
    logic              awvalid;
    logic              awready = 1'b0;
    logic [63:0]       wdata;
    logic [7:0]        wstrb;
    logic              wlast;
    logic              wvalid;
    logic              wready = 1'b0;
    logic [1:0]        bresp = 2'b00;
    logic              bvalid = 1'b0;
    logic              bready;

    ring_burst_writer #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_DEPTH(DEPTH), .RESP_W(RESP_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en), .base_addr_i(base),
        .word_cnt_o(word_cnt), .resp_cnt_o(resp_cnt), .err_o(err),
        .s_axis_tdata(tdata), .s_axis_tvalid(tvalid), .s_axis_tready(tready),
        .m_axi_awaddr(awaddr), .m_axi_awlen(awlen), .m_axi_awsize(awsize),
        .m_axi_awburst(awburst), .m_axi_awvalid(awvalid), .m_axi_awready(awready),
        .m_axi_wdata(wdata), .m_axi_wstrb(wstrb), .m_axi_wlast(wlast),
        .m_axi_wvalid(wvalid), .m_axi_wready(wready),
        .m_axi_bresp(bresp), .m_axi_bvalid(bvalid), .m_axi_bready(bready)
    );

    always #10 clk = ~clk;

    // stimulus knobs, in percent
    int tv_pct = 100, aw_pct = 100, w_pct = 100, b_pct = 100;
    bit inject_err = 1'b0;

    // reference model
    logic [63:0] q[$];
    int          phase = 0;   // 0 idle, 1 address, 2 data, 3 response
    int          beat = 0;
    logic [31:0] exp_addr = '0;
    int          exp_cnt = 0;
    int          exp_resp = 0;
    bit          exp_err = 1'b0;
    bit          bpend = 1'b0;
    bit          t_taken = 1'b0;
    bit          b_taken = 1'b0;
    longint      seq = 0;
    int          cycles = 0;
    int          errors = 0;
    int          checks = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic bit roll(input int pct);
        return int'($urandom_range(99)) < pct;
    endfunction

    always @(negedge clk) begin
        int ph;
        cycles++;
        if (cycles >= WDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, WDOG);
            report();
            $finish;
        end
        if (!rst_n) begin
            q.delete();
            phase = 0; beat = 0; exp_cnt = 0; exp_resp = 0; exp_err = 1'b0;
            bpend = 1'b0; t_taken = 1'b0; b_taken = 1'b0;
            tvalid = 1'b0; awready = 1'b0; wready = 1'b0; bvalid = 1'b0;
        end else begin
            // compare outputs with the model
            check(word_cnt == CNT_W'(exp_cnt), "R6 R8 word counter", word_cnt, exp_cnt);
            check(resp_cnt == RESP_W'(exp_resp), "R10 response count", resp_cnt, exp_resp);
            check(err == exp_err, "R11 error flag", err, exp_err);
            check(awvalid == (phase == 1), "R9 R12 awvalid", awvalid, phase == 1);
            check(wvalid == (phase == 2), "R9 R12 wvalid", wvalid, phase == 2);
            check(bready == (phase == 3), "R9 bready", bready, phase == 3);
            check(tready == (en && q.size() < DEPTH), "R7 tready", tready,
                  en && q.size() < DEPTH);
            if (awvalid) begin
                check(awaddr == exp_addr, "R3 R12 awaddr", awaddr, exp_addr);
                check(awlen == 8'd15 && awsize == 3'd3 && awburst == 2'b01,
                      "R2 burst attributes", {awlen, awsize, awburst}, {8'd15, 3'd3, 2'b01});
                check(q.size() >= 16, "R4 words buffered", q.size(), 16);
            end
            if (wvalid && q.size() > 0) begin
                check(wdata == q[0], "R5 R12 beat data", wdata, q[0]);
                check(wlast == (beat == 15), "R2 wlast", wlast, beat == 15);
                check(wstrb == 8'hFF, "R2 wstrb", wstrb, 8'hFF);
            end
            // drive the stream source and memory slave
            if (!(tvalid && !t_taken)) tvalid = roll(tv_pct);
            tdata = 64'h5A00_0000_0000_0000 | 64'(seq);
            awready = roll(aw_pct);
            wready  = roll(w_pct);
            if (b_taken) bvalid = 1'b0;
            if (!bvalid && bpend && roll(b_pct)) begin
                bvalid = 1'b1;
                bresp  = inject_err ? 2'b10 : 2'b00;
            end
            t_taken = 1'b0;
            b_taken = 1'b0;
            #1;
            // advance the model across the coming edge
            ph = phase;
            case (ph)
                0: if (en && q.size() >= 16) begin
                    phase = 1;
                    exp_addr = (base & ~32'h7F) + 32'(exp_cnt * 8);
                end
                1: if (awready) begin phase = 2; beat = 0; end
                2: if (wready) begin
                    void'(q.pop_front());
                    if (beat == 15) begin phase = 3; bpend = 1'b1; end
                    beat++;
                end
                default: if (bvalid) phase = 0;
            endcase
            if (!en) exp_cnt = 0;
            else if (ph == 3 && bvalid) exp_cnt = (exp_cnt + 16) % (1 << CNT_W);
            if (ph == 3 && bvalid) begin
                exp_resp++;
                if (bresp != 2'b00) exp_err = 1'b1;
                bpend = 1'b0;
                b_taken = 1'b1;
            end
            if (tvalid && tready) begin
                q.push_back(tdata);
                seq++;
                t_taken = 1'b1;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_resp(input int target);
        while (exp_resp < target) cyc(1);
    endtask

    initial begin
        int r0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check(word_cnt == '0, "R1 counter after reset", word_cnt, 0);
        check(resp_cnt == '0, "R1 response count after reset", resp_cnt, 0);
        check(err == 1'b0, "R1 error after reset", err, 0);
        check(!awvalid && !wvalid && !bready, "R1 handshakes idle",
              {awvalid, wvalid, bready}, 0);
        check(tready == 1'b1, "R1 tready after reset", tready, 1);

        // full rate, counter wrap after 16 bursts
        wait_resp(16);
        check(word_cnt == CNT_W'(exp_resp * 16), "R6 wrap of counter", word_cnt,
              CNT_W'(exp_resp * 16));
        wait_resp(20);

        // random stalls on every channel
        tv_pct = 60; aw_pct = 50; w_pct = 70; b_pct = 40;
        wait_resp(32);

        // FIFO fills while the address channel is blocked
        tv_pct = 100; aw_pct = 0;
        cyc(80);
        check(tready == 1'b0, "R7 stall at full FIFO", tready, 0);
        check(awvalid == 1'b1, "R12 address held while blocked", awvalid, 1);
        aw_pct = 100;
        wait_resp(36);

        // misaligned base: low bits ignored
        base = 32'h0000_2345;
        while (!awvalid) cyc(1);
        check(awaddr == 32'h0000_2300 + 32'(word_cnt) * 8, "R3 aligned base",
              awaddr, 32'h0000_2300 + 32'(word_cnt) * 8);
        wait_resp(40);

        // enable dropped during a burst's data phase
        w_pct = 50; tv_pct = 80;
        while (!wvalid) cyc(1);
        en = 1'b0;
        r0 = exp_resp;
        wait_resp(r0 + 1);
        cyc(1);
        check(word_cnt == '0, "R8 counter cleared while disabled", word_cnt, 0);
        cyc(30);
        check(resp_cnt == RESP_W'(r0 + 1), "R8 in-flight burst completed", resp_cnt, r0 + 1);
        check(!awvalid && !wvalid, "R8 no new burst while disabled", {awvalid, wvalid}, 0);
        check(tready == 1'b0, "R7 R8 stream stalled while disabled", tready, 0);
        en = 1'b1;
        while (!awvalid) cyc(1);
        check(awaddr == 32'h0000_2300, "R8 R3 restart at ring base", awaddr, 32'h0000_2300);
        wait_resp(r0 + 4);

        // error response
        check(err == 1'b0, "R11 no error before bad response", err, 0);
        inject_err = 1'b1;
        wait_resp(r0 + 5);
        inject_err = 1'b0;
        cyc(1);
        check(err == 1'b1, "R11 error set by bad response", err, 1);
        wait_resp(r0 + 7);
        check(err == 1'b1, "R11 error stays set", err, 1);
        check(resp_cnt == RESP_W'(exp_resp), "R10 final response count", resp_cnt, exp_resp);

        report();
        $finish;
    end
endmodule